// File: doc/BRIEF.md
# Serial DAC Front-End Controller

This block is the digital front end of a 12-bit voltage-output converter. A host shifts 16-bit words into it over a three-wire serial link made of an active-low select, a serial clock and a data line. Each accepted word carries a two-bit command and a 12-bit code. The command either stages the code in an input register, moves the staged code into the converter register, or writes both registers at once. The converter register drives the analog ladder, which lies outside this block.

The block also keeps a low-power shutdown state. Software enters it with a serial command, and hardware enters it with a rising edge on a sleep-request pin. Both routes work only while the sleep-allow pin is high. Shutdown ends on a falling edge of sleep-allow, or when an accepted word writes the converter register. Staged data survives shutdown, so the previous output comes back when the block wakes. After every wake-up a counter holds the settle-ready flag low for a programmable number of system clocks.

All pins are asynchronous to the system clock. Each one passes through a two-stage synchronizer before it is used.

Top module: `dac_serial_front`

## Requirements
- R1: Out of reset the converter code is 0, the shutdown flag is 0 and settle-ready is 1.
- R2: A frame is the serial bits sampled on serial-clock rising edges while select is low. Its first two bits are the command and the next 12 are the code, most significant bit first. The last two bits have no effect on the result.
- R3: Command 00 writes the input register only. The converter code does not change.
- R4: Command 01 writes the code into both the input register and the converter register.
- R5: Command 10 copies the input register into the converter register.
- R6: The command is carried out when select rises, and only if exactly 16 serial clocks were seen. A frame of any other length changes neither register.
- R7: Command 11 enters shutdown while sleep-allow is high. While sleep-allow is low it is ignored.
- R8: A rising edge on sleep-request enters shutdown while sleep-allow is high. It is ignored while sleep-allow is low, and lowering sleep-request does not leave shutdown.
- R9: A falling edge on sleep-allow leaves shutdown, and the converter code is unchanged.
- R10: In shutdown, frames are still accepted. Command 00 updates the input register and the block stays in shutdown. Commands 01 and 10 update the converter register and leave shutdown.
- R11: When shutdown ends, settle-ready goes low for exactly SETTLE_CYCLES clocks and then returns high.
- R12: If a sleep-request rise and a waking frame are acted on in the same clock, the block stays in shutdown. The frame's register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; its rising edge ends a frame |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data |
| sleep_req | input | 1 | Hardware shutdown request, acted on at its rising edge |
| sleep_allow | input | 1 | High permits shutdown; a falling edge wakes the block |
| dac_code | output | 12 | Converter register contents |
| in_shutdown | output | 1 | High while the block is in shutdown |
| settle_ready | output | 1 | Low during the settle interval after a wake-up |

## Verification
A frame that wakes the block (command 01 or 10) can be acted on in the same clock as a sleep-request rising edge. The two events then give opposite orders for the shutdown state. The bench provokes this by raising select and sleep-request at the same instant. Both pins have the same synchronizer depth, so both events reach the control logic in one clock. The result is judged at the ports: the new code must appear on the converter output, the shutdown flag must stay high, and settle-ready must never drop.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    // Command field carried in the first two bits of a frame
    typedef enum logic [1:0] {
        CMD_STAGE = 2'b00,
        CMD_BOTH  = 2'b01,
        CMD_XFER  = 2'b10,
        CMD_SLEEP = 2'b11
    } dfs_cmd_e;

    // Bit positions of the synchronized pin vector
    localparam int PIN_SEL   = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_REQ   = 2;
    localparam int PIN_ALLOW = 3;
    localparam int PIN_SDI   = 4;
    localparam int PIN_NUM   = 5;
    localparam int EDGE_NUM  = 4;
endpackage

// File: rtl/dfs_sync.sv
module dfs_sync #(
    parameter int             N       = 5,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [1:0] ff_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= {2{RST_VAL[g]}};
            else        ff_q <= {ff_q[0], pin[g]};
        end
        assign lvl[g] = ff_q[1];
    end
endmodule

// File: rtl/dfs_shifter.sv
module dfs_shifter #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl,
    input  logic              sel_fall,
    input  logic              sel_rise,
    input  logic              sck_rise,
    input  logic              sdi,
    output logic              frame_vld,
    output logic [1:0]        frame_ctrl,
    output logic [DATA_W-1:0] frame_data,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (sel_fall) begin
            sh_d.cnt = '0;
        end else if (sck_rise && !sel_lvl) begin
            sh_d.sh = {sh_q.sh[FRAME_W-2:0], sdi};
            if (sh_q.cnt != CNT_SAT) sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame_vld  = sel_rise && (sh_q.cnt == CNT_FULL);
    assign frame_ctrl = sh_q.sh[FRAME_W-1 -: 2];
    assign frame_data = sh_q.sh[FRAME_W-3 -: DATA_W];
    assign bit_cnt    = sh_q.cnt;
endmodule

// File: rtl/dfs_settle.sv
module dfs_settle #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int               W    = $clog2(CYCLES + 1);
    localparam logic [W-1:0]     LOAD = W'(CYCLES);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = LOAD;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
    parameter int DATA_W        = 12,
    parameter int SETTLE_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              sleep_req,
    input  logic              sleep_allow,
    output logic [DATA_W-1:0] dac_code,
    output logic              in_shutdown,
    output logic              settle_ready
);
    import dfs_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [PIN_NUM-1:0]  PIN_RST  = PIN_NUM'(1) << PIN_SEL;
    localparam logic [EDGE_NUM-1:0] EDGE_RST = PIN_RST[EDGE_NUM-1:0];

    typedef struct packed {
        logic [DATA_W-1:0]   inreg;
        logic [DATA_W-1:0]   dac;
        logic                shut;
        logic [EDGE_NUM-1:0] prev;
    } ctl_t;

    localparam ctl_t CTL_RST = '{inreg: '0, dac: '0, shut: 1'b0, prev: EDGE_RST};

    logic [PIN_NUM-1:0] pin_s;
    logic               sel_rise, sel_fall, sck_rise, req_rise, allow_fall, allow_s;
    logic               frame_vld;
    logic [1:0]         frame_ctrl;
    logic [DATA_W-1:0]  frame_data;
    logic [CNT_W-1:0]   bit_cnt;
    logic               go_sleep, wake;
    ctl_t               st_d, st_q;

    dfs_sync #(.N(PIN_NUM), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({sdi, sleep_allow, sleep_req, sck, cs_n}),
        .lvl   (pin_s)
    );

    assign allow_s    = pin_s[PIN_ALLOW];
    assign sel_rise   =  pin_s[PIN_SEL]   & ~st_q.prev[PIN_SEL];
    assign sel_fall   = ~pin_s[PIN_SEL]   &  st_q.prev[PIN_SEL];
    assign sck_rise   =  pin_s[PIN_SCK]   & ~st_q.prev[PIN_SCK];
    assign req_rise   =  pin_s[PIN_REQ]   & ~st_q.prev[PIN_REQ];
    assign allow_fall = ~pin_s[PIN_ALLOW] &  st_q.prev[PIN_ALLOW];

    dfs_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_lvl    (pin_s[PIN_SEL]),
        .sel_fall   (sel_fall),
        .sel_rise   (sel_rise),
        .sck_rise   (sck_rise),
        .sdi        (pin_s[PIN_SDI]),
        .frame_vld  (frame_vld),
        .frame_ctrl (frame_ctrl),
        .frame_data (frame_data),
        .bit_cnt    (bit_cnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_s[EDGE_NUM-1:0];
        go_sleep  = 1'b0;
        wake      = 1'b0;
        if (frame_vld) begin
            case (dfs_cmd_e'(frame_ctrl))
                CMD_STAGE: st_d.inreg = frame_data;
                CMD_BOTH: begin
                    st_d.inreg = frame_data;
                    st_d.dac   = frame_data;
                    wake       = 1'b1;
                end
                CMD_XFER: begin
                    st_d.dac = st_q.inreg;
                    wake     = 1'b1;
                end
                default: go_sleep = allow_s;
            endcase
        end
        if (allow_fall)            wake     = 1'b1;
        if (req_rise && allow_s)   go_sleep = 1'b1;
        // a request to sleep outranks a wake event in the same cycle
        if (go_sleep)              st_d.shut = 1'b1;
        else if (wake)             st_d.shut = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RST;
        else        st_q <= st_d;
    end

    dfs_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_q.shut & ~st_d.shut),
        .ready (settle_ready)
    );

    assign dac_code    = st_q.dac;
    assign in_shutdown = st_q.shut;
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_vld,
    input logic [1:0]        frame_ctrl,
    input logic [DATA_W-1:0] frame_data,
    input logic              sel_rise,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              allow_s,
    input logic [DATA_W-1:0] dac_code,
    input logic              in_shutdown,
    input logic              settle_ready
);
    AST_STAGE_KEEPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && frame_ctrl == 2'b00 |=> $stable(dac_code)); // R3

    AST_BOTH_LOADS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && frame_ctrl == 2'b01 |=> dac_code == $past(frame_data)); // R4

    AST_BAD_LENGTH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise && bit_cnt != CNT_W'(FRAME_W) |=> $stable(dac_code)); // R6

    AST_SLEEP_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_shutdown) |-> $past(allow_s)); // R7

    AST_WAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_shutdown) |-> !settle_ready); // R11
endmodule

bind dac_serial_front dfs_checker #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_dfs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_vld    (frame_vld),
    .frame_ctrl   (frame_ctrl),
    .frame_data   (frame_data),
    .sel_rise     (sel_rise),
    .bit_cnt      (bit_cnt),
    .allow_s      (allow_s),
    .dac_code     (dac_code),
    .in_shutdown  (in_shutdown),
    .settle_ready (settle_ready)
);

// File: tb/test_dac_serial_front.sv
module test_dac_serial_front;
    localparam int SETTLE = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic        sleep_req = 1'b0, sleep_allow = 1'b0;
    logic [11:0] dac_code;
    logic        in_shutdown, settle_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] dac;
        logic        shut;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    dac_serial_front #(.DATA_W(12), .SETTLE_CYCLES(SETTLE)) i_dac_serial_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sck          (sck),
        .sdi          (sdi),
        .sleep_req    (sleep_req),
        .sleep_allow  (sleep_allow),
        .dac_code     (dac_code),
        .in_shutdown  (in_shutdown),
        .settle_ready (settle_ready)
    );

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // driver side: push the outputs expected now
    task automatic expect_out(input logic [11:0] d, input logic s, input string tag);
        exp_t e;
        e.dac = d; e.shut = s; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops each expected item and compares it with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(dac_code === e.dac && in_shutdown === e.shut, e.tag,
                    $sformatf("dac=%h shut=%b", dac_code, in_shutdown),
                    $sformatf("dac=%h shut=%b", e.dac, e.shut));
            end
        end
    end

    function automatic logic [15:0] mk(input logic [1:0] c, input logic [11:0] d,
                                       input logic [1:0] sub);
        return {c, d, sub};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, input bit req_at_end);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        if (req_at_end) sleep_req = 1'b1;
        wait_clk(10);
    endtask

    initial begin
        wait_clk(100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int guard;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        expect_out(12'h000, 1'b0, "R1 reset");
        chk(settle_ready === 1'b1, "R1 ready", $sformatf("%b", settle_ready), "1");

        // R3 and R2: stage only, trailing bits set
        frame(mk(2'b00, 12'hA5C, 2'b11), 16, 1'b0);
        expect_out(12'h000, 1'b0, "R3 stage only");
        // R5 copy
        frame(mk(2'b10, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'hA5C, 1'b0, "R5 copy staged");
        // R4 and R2: trailing bits differ
        frame(mk(2'b01, 12'h3F1, 2'b10), 16, 1'b0);
        expect_out(12'h3F1, 1'b0, "R4 load both / R2 order");

        // R6: short and long frames dropped
        frame(mk(2'b01, 12'h777, 2'b00), 15, 1'b0);
        expect_out(12'h3F1, 1'b0, "R6 short frame");
        frame(mk(2'b01, 12'h777, 2'b00), 17, 1'b0);
        expect_out(12'h3F1, 1'b0, "R6 long frame");
        frame(mk(2'b10, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'h3F1, 1'b0, "R6 input register untouched");

        // R7, R8: lockout blocks both routes (sleep_allow is low)
        frame(mk(2'b11, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'h3F1, 1'b0, "R7 command blocked");
        sleep_req = 1'b1;
        wait_clk(10);
        expect_out(12'h3F1, 1'b0, "R8 pin blocked");
        sleep_req = 1'b0;
        sleep_allow = 1'b1;
        wait_clk(10);

        // R7 command enters shutdown
        frame(mk(2'b11, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'h3F1, 1'b1, "R7 command sleeps");
        chk(settle_ready === 1'b1, "R7 ready kept", $sformatf("%b", settle_ready), "1");
        // R10 staging in shutdown
        frame(mk(2'b00, 12'h5AA, 2'b00), 16, 1'b0);
        expect_out(12'h3F1, 1'b1, "R10 stage keeps shutdown");

        // R9 wake by lockout fall, R11 settle length
        sleep_allow = 1'b0;
        guard = 0;
        while (in_shutdown && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        n = 0;
        while (!settle_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == SETTLE, "R11 settle length", $sformatf("%0d", n), $sformatf("%0d", SETTLE));
        expect_out(12'h3F1, 1'b0, "R9 wake keeps code");
        sleep_allow = 1'b1;
        wait_clk(10);

        // R8 pin entry, falling request does not wake
        sleep_req = 1'b1;
        wait_clk(10);
        expect_out(12'h3F1, 1'b1, "R8 pin sleeps");
        sleep_req = 1'b0;
        wait_clk(10);
        expect_out(12'h3F1, 1'b1, "R8 request fall no wake");
        // R10 copy wakes with staged data
        frame(mk(2'b10, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'h5AA, 1'b0, "R10 copy wakes");
        chk(settle_ready === 1'b0, "R11 ready low", $sformatf("%b", settle_ready), "0");
        wait_clk(40);
        chk(settle_ready === 1'b1, "R11 ready back", $sformatf("%b", settle_ready), "1");

        // R12 collision: waking frame and pin rise acted on together
        frame(mk(2'b11, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'h5AA, 1'b1, "R7 sleep again");
        frame(mk(2'b01, 12'h0C3, 2'b00), 16, 1'b1);
        expect_out(12'h0C3, 1'b1, "R12 sleep wins, code written");
        chk(settle_ready === 1'b1, "R12 no settle", $sformatf("%b", settle_ready), "1");
        sleep_req = 1'b0;
        sleep_allow = 1'b0;
        wait_clk(10);
        expect_out(12'h0C3, 1'b0, "R9 wake after collision");
        wait_clk(40);
        sleep_allow = 1'b1;
        wait_clk(10);

        // boundary codes
        frame(mk(2'b01, 12'hFFF, 2'b01), 16, 1'b0);
        expect_out(12'hFFF, 1'b0, "R4 full scale");
        frame(mk(2'b00, 12'h000, 2'b00), 16, 1'b0);
        expect_out(12'hFFF, 1'b0, "R3 stage zero");
        frame(mk(2'b10, 12'hFFF, 2'b11), 16, 1'b0);
        expect_out(12'h000, 1'b0, "R5 copy zero");

        wait_clk(5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule